// File: doc/BRIEF.md
# PLL Lock Detect and Holdover Controller

This block is the digital supervisor of a clock synthesizer loop. Once per phase-detector cycle it receives a strobe and two flags from the analog skew measurement: one saying both edges fell inside the wide (high range) window and one for the narrow (low range) window. A configuration bit picks which flag counts. The block counts consecutive qualifying cycles in a saturating counter. It raises a lock indicator once a programmable number of them has been seen. A single bad cycle clears the count.

A three-state machine sits on top of the lock indicator and freezes the loop when lock is lost. In ARMED, a drop of lock while the qualified LD level is high takes it to HOLD (ARMED -> HOLD). In HOLD it requests the charge pump to go high-impedance until an edge arrives on the currently selected reference (HOLD -> REACQUIRE). In REACQUIRE it waits until lock is declared again and the qualified LD level is high (REACQUIRE -> ARMED). Only then can a new holdover happen. The LD level comes from a sampled comparator bit, or is taken as constantly high when the comparator is disabled. An external mode replaces the automatic machine with a direct holdover request input. A global enable gates both modes.

Top module: `pll_holdover_ctrl`

## Requirements
- R1: With count code 00, `lock_o` rises after the clock edge at which the fifth consecutive qualifying strobe is taken. It stays low after four.
- R2: Count codes 01, 10 and 11 need 16, 64 and 255 consecutive qualifying strobes. The counter saturates at 255, so further qualifying strobes keep lock high and never wrap.
- R3: A strobe whose selected window flag is 0 clears the count, and `lock_o` is low after that edge. Cycles without a strobe leave the count and lock unchanged.
- R4: `cfg_win_narrow_i` = 0 qualifies strobes with `win_wide_ok_i`. A value of 1 qualifies them with `win_narrow_ok_i`, and the other flag is then ignored.
- R5: While `cfg_dld_off_i` = 1 the count is held at zero, `lock_o` is low one edge later, and automatic holdover never asserts.
- R6: With `cfg_hold_en_i` = 0, `holdover_o` is 0 in both automatic and external modes.
- R7: ARMED -> HOLD when the machine samples lock low while the qualified LD level is high. `holdover_o` rises one edge after `lock_o` falls.
- R8: HOLD -> REACQUIRE on an edge of the selected reference, where `ref_sel_i` = k selects `ref_edge_i[k]`. Edges on other references leave holdover active.
- R9: REACQUIRE -> ARMED only when lock and the qualified LD level are both high. A lock loss while in REACQUIRE does not assert holdover.
- R10: With `cfg_ld_cmp_en_i` = 0 the qualified LD level is 1 regardless of `ld_cmp_i`. With it set to 1, the level equals `ld_cmp_i`.
- R11: With `cfg_ext_mode_i` = 1 and the global enable set, `holdover_o` equals `ext_hold_req_i` in the same cycle, and automatic holdover never asserts.
- R12: `cp_hiz_o` equals `holdover_o` in every cycle.
- R13: Synchronous reset clears the count, drops lock and puts the machine in REACQUIRE, so a strobe outside the window straight after reset causes no holdover.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pfd_strobe_i | input | 1 | One pulse per phase-detector cycle |
| win_wide_ok_i | input | 1 | Both edges inside the wide window |
| win_narrow_ok_i | input | 1 | Both edges inside the narrow window |
| ref_edge_i | input | NUM_REF (2) | Per-reference edge pulses at the detector |
| ref_sel_i | input | SEL_W (1) | Index of the selected reference |
| ld_cmp_i | input | 1 | Sampled LD comparator bit |
| ext_hold_req_i | input | 1 | Holdover request used in external mode |
| cfg_cnt_code_i | input | 2 | Lock count code |
| cfg_win_narrow_i | input | 1 | 1 selects the narrow window flag |
| cfg_dld_off_i | input | 1 | 1 disables lock detection |
| cfg_hold_en_i | input | 1 | Global holdover enable |
| cfg_ext_mode_i | input | 1 | 1 selects external holdover control |
| cfg_ld_cmp_en_i | input | 1 | 1 uses the LD comparator, 0 forces the level high |
| lock_o | output | 1 | Lock indicator |
| holdover_o | output | 1 | Holdover active |
| cp_hiz_o | output | 1 | Charge-pump high-impedance request |

## Verification
The assertions assume that reset is held during the first clock edge. They also assume the configuration inputs change only between edges, so that a window flag sampled with a strobe belongs to that strobe. The stimulus drives every input just after the falling edge. It holds reset for several cycles at time zero and changes the configuration only at cycle boundaries, in blocks. Random phases keep the window flags mostly good so that lock is reached. Reference edges and comparator changes are made rare enough that all three states and both exits are visited.

// File: rtl/pllhd_pkg.sv
package pllhd_pkg;

    typedef enum logic [1:0] {
        HS_ARMED = 2'd0,
        HS_HOLD  = 2'd1,
        HS_REACQ = 2'd2
    } hold_state_e;

endpackage

// File: rtl/pllhd_lock_counter.sv
module pllhd_lock_counter #(
    parameter int CNT_W  = 8,
    parameter int THR_C0 = 5,
    parameter int THR_C1 = 16,
    parameter int THR_C2 = 64,
    parameter int THR_C3 = 255
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       strobe_i,
    input  logic       win_wide_ok_i,
    input  logic       win_narrow_ok_i,
    input  logic       win_narrow_sel_i,
    input  logic       dld_off_i,
    input  logic [1:0] code_i,
    output logic       lock_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    function automatic logic [CNT_W-1:0] thr_of(input logic [1:0] code);
        logic [CNT_W-1:0] t;
        case (code)
            2'd0:    t = CNT_W'(THR_C0);
            2'd1:    t = CNT_W'(THR_C1);
            2'd2:    t = CNT_W'(THR_C2);
            default: t = CNT_W'(THR_C3);
        endcase
        return t;
    endfunction

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic             lock_q;
    logic             lock_d;
    logic             in_win;

    always_comb begin
        in_win = win_narrow_sel_i ? win_narrow_ok_i : win_wide_ok_i;
        cnt_d  = cnt_q;
        if (dld_off_i) begin
            cnt_d = '0;
        end else if (strobe_i) begin
            if (!in_win) begin
                cnt_d = '0;
            end else if (cnt_q != CNT_MAX) begin
                cnt_d = cnt_q + 1'b1;
            end
        end
        lock_d = !dld_off_i && (cnt_d >= thr_of(code_i));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            lock_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            lock_q <= lock_d;
        end
    end

    assign lock_o = lock_q;

    // R3
    clear_drops_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (strobe_i && !in_win) |=> !lock_o);

    // R5
    dld_off_no_lock_chk: assert property (@(posedge clk) disable iff (rst)
        dld_off_i |=> !lock_o);

    // R2
    sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == CNT_MAX && strobe_i && in_win && !dld_off_i) |=> (cnt_q == CNT_MAX));

endmodule

// File: rtl/pllhd_ref_qual.sv
module pllhd_ref_qual #(
    parameter int NUM_REF = 2,
    parameter int SEL_W   = 1
) (
    input  logic [NUM_REF-1:0] ref_edge_i,
    input  logic [SEL_W-1:0]   ref_sel_i,
    input  logic               ld_cmp_i,
    input  logic               ld_cmp_en_i,
    output logic               sel_edge_o,
    output logic               ld_ok_o
);

    logic [NUM_REF-1:0] hit;

    for (genvar k = 0; k < NUM_REF; k++) begin : g_ref
        assign hit[k] = ref_edge_i[k] && (ref_sel_i == SEL_W'(k));
    end

    assign sel_edge_o = |hit;
    assign ld_ok_o    = ld_cmp_en_i ? ld_cmp_i : 1'b1;

endmodule

// File: rtl/pllhd_hold_fsm.sv
module pllhd_hold_fsm
    import pllhd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic lock_i,
    input  logic ld_ok_i,
    input  logic ref_edge_i,
    input  logic hold_en_i,
    input  logic ext_mode_i,
    input  logic ext_req_i,
    input  logic dld_off_i,
    output logic holdover_o,
    output logic cp_hiz_o
);

    hold_state_e state_q;
    hold_state_e state_d;
    logic        auto_en;

    assign auto_en = hold_en_i && !ext_mode_i && !dld_off_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HS_ARMED: begin
                if (!auto_en) begin
                    state_d = HS_REACQ;
                end else if (!lock_i && ld_ok_i) begin
                    state_d = HS_HOLD;
                end
            end
            HS_HOLD: begin
                if (!auto_en || ref_edge_i) begin
                    state_d = HS_REACQ;
                end
            end
            HS_REACQ: begin
                if (auto_en && lock_i && ld_ok_i) begin
                    state_d = HS_ARMED;
                end
            end
            default: state_d = HS_REACQ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= HS_REACQ;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        holdover_o = (auto_en && state_q == HS_HOLD)
                   || (hold_en_i && ext_mode_i && ext_req_i);
        cp_hiz_o   = holdover_o;
    end

    // R6
    hold_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !hold_en_i |-> !cp_hiz_o);

    // R7
    enter_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == HS_ARMED && auto_en && !lock_i && ld_ok_i) |=> (state_q == HS_HOLD));

    // R8
    leave_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == HS_HOLD && ref_edge_i) |=> (state_q == HS_REACQ));

    // R9
    rearm_guard_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == HS_REACQ && !(lock_i && ld_ok_i)) |=> (state_q != HS_ARMED));

endmodule

// File: rtl/pll_holdover_ctrl.sv
module pll_holdover_ctrl #(
    parameter int CNT_W   = 8,
    parameter int THR_C0  = 5,
    parameter int THR_C1  = 16,
    parameter int THR_C2  = 64,
    parameter int THR_C3  = 255,
    parameter int NUM_REF = 2,
    parameter int SEL_W   = (NUM_REF > 1) ? $clog2(NUM_REF) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pfd_strobe_i,
    input  logic               win_wide_ok_i,
    input  logic               win_narrow_ok_i,
    input  logic [NUM_REF-1:0] ref_edge_i,
    input  logic [SEL_W-1:0]   ref_sel_i,
    input  logic               ld_cmp_i,
    input  logic               ext_hold_req_i,
    input  logic [1:0]         cfg_cnt_code_i,
    input  logic               cfg_win_narrow_i,
    input  logic               cfg_dld_off_i,
    input  logic               cfg_hold_en_i,
    input  logic               cfg_ext_mode_i,
    input  logic               cfg_ld_cmp_en_i,
    output logic               lock_o,
    output logic               holdover_o,
    output logic               cp_hiz_o
);

    logic lock_w;
    logic sel_edge_w;
    logic ld_ok_w;

    pllhd_lock_counter #(
        .CNT_W (CNT_W),
        .THR_C0(THR_C0),
        .THR_C1(THR_C1),
        .THR_C2(THR_C2),
        .THR_C3(THR_C3)
    ) u_lock (
        .clk             (clk),
        .rst             (rst),
        .strobe_i        (pfd_strobe_i),
        .win_wide_ok_i   (win_wide_ok_i),
        .win_narrow_ok_i (win_narrow_ok_i),
        .win_narrow_sel_i(cfg_win_narrow_i),
        .dld_off_i       (cfg_dld_off_i),
        .code_i          (cfg_cnt_code_i),
        .lock_o          (lock_w)
    );

    pllhd_ref_qual #(
        .NUM_REF(NUM_REF),
        .SEL_W  (SEL_W)
    ) u_ref (
        .ref_edge_i (ref_edge_i),
        .ref_sel_i  (ref_sel_i),
        .ld_cmp_i   (ld_cmp_i),
        .ld_cmp_en_i(cfg_ld_cmp_en_i),
        .sel_edge_o (sel_edge_w),
        .ld_ok_o    (ld_ok_w)
    );

    pllhd_hold_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .lock_i    (lock_w),
        .ld_ok_i   (ld_ok_w),
        .ref_edge_i(sel_edge_w),
        .hold_en_i (cfg_hold_en_i),
        .ext_mode_i(cfg_ext_mode_i),
        .ext_req_i (ext_hold_req_i),
        .dld_off_i (cfg_dld_off_i),
        .holdover_o(holdover_o),
        .cp_hiz_o  (cp_hiz_o)
    );

    assign lock_o = lock_w;

    // R11
    ext_no_auto_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_ext_mode_i && !ext_hold_req_i) |-> !holdover_o);

endmodule

// File: tb/test_pll_holdover_ctrl.sv
module test_pll_holdover_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       strobe = 1'b0, wok = 1'b0, nok = 1'b0;
    logic [1:0] redge = 2'b00;
    logic [0:0] rsel = 1'b0;
    logic       ld = 1'b0, ereq = 1'b0;
    logic [1:0] code = 2'd0;
    logic       narrow = 1'b0, dld_off = 1'b0, hen = 1'b1, ext = 1'b0, ld_en = 1'b0;
    logic       lock_o, holdover_o, cp_hiz_o;

    int checks = 0;
    int errors = 0;
    int m_cnt = 0;
    bit m_lock = 1'b0;
    int m_st = 2;

    always #10 clk = ~clk;

    pll_holdover_ctrl i_pll_holdover_ctrl (
        .clk(clk), .rst(rst), .pfd_strobe_i(strobe), .win_wide_ok_i(wok),
        .win_narrow_ok_i(nok), .ref_edge_i(redge), .ref_sel_i(rsel), .ld_cmp_i(ld),
        .ext_hold_req_i(ereq), .cfg_cnt_code_i(code), .cfg_win_narrow_i(narrow),
        .cfg_dld_off_i(dld_off), .cfg_hold_en_i(hen), .cfg_ext_mode_i(ext),
        .cfg_ld_cmp_en_i(ld_en), .lock_o(lock_o), .holdover_o(holdover_o), .cp_hiz_o(cp_hiz_o)
    );

    function automatic int thr(input logic [1:0] c);
        case (c)
            2'd0: return 5;
            2'd1: return 16;
            2'd2: return 64;
            default: return 255;
        endcase
    endfunction

    function automatic bit exp_hold();
        bit auto_en = hen && !ext && !dld_off;
        return (auto_en && m_st == 1) || (hen && ext && ereq);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_update();
        bit auto_en, ldok, sedge, inwin;
        int nst;
        if (rst) begin
            m_cnt = 0; m_lock = 0; m_st = 2;
            return;
        end
        auto_en = hen && !ext && !dld_off;
        ldok = ld_en ? ld : 1'b1;
        sedge = redge[rsel];
        nst = m_st;
        case (m_st)
            0: if (!auto_en) nst = 2; else if (!m_lock && ldok) nst = 1;
            1: if (!auto_en || sedge) nst = 2;
            default: if (auto_en && m_lock && ldok) nst = 0;
        endcase
        m_st = nst;
        inwin = narrow ? nok : wok;
        if (dld_off) m_cnt = 0;
        else if (strobe) m_cnt = inwin ? ((m_cnt < 255) ? m_cnt + 1 : 255) : 0;
        m_lock = !dld_off && (m_cnt >= thr(code));
    endtask

    task automatic tick();
        @(posedge clk);
        model_update();
        @(negedge clk);
        chk("R3 lock model", int'(lock_o), int'(m_lock));
        chk("R7 holdover model", int'(holdover_o), int'(exp_hold()));
        chk("R12 cp_hiz", int'(cp_hiz_o), int'(exp_hold()));
    endtask

    task automatic strobes(input int n, input bit w, input bit nw);
        for (int i = 0; i < n; i++) begin
            strobe = 1'b1; wok = w; nok = nw;
            tick();
        end
        strobe = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic pulse_ref(input logic [1:0] e);
        redge = e;
        tick();
        redge = 2'b00;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        idle(3);
        rst = 1'b0;
        chk("R13 lock after reset", lock_o, 0);
        chk("R13 holdover after reset", holdover_o, 0);
        strobes(1, 0, 0); idle(2);
        chk("R13 no holdover from REACQUIRE", holdover_o, 0);

        strobes(4, 1, 1);
        chk("R1 four strobes", lock_o, 0);
        strobes(1, 1, 1);
        chk("R1 fifth strobe", lock_o, 1);
        idle(1);
        strobes(1, 0, 0);
        chk("R3 bad strobe drops lock", lock_o, 0);
        chk("R7 holdover not yet", holdover_o, 0);
        idle(1);
        chk("R7 holdover after lock loss (R10 ld forced high)", holdover_o, 1);
        chk("R12 cp_hiz in holdover", cp_hiz_o, 1);
        pulse_ref(2'b10);
        chk("R8 unselected edge ignored", holdover_o, 1);
        pulse_ref(2'b01);
        chk("R8 selected edge exits", holdover_o, 0);

        ld_en = 1'b1; ld = 1'b0;
        strobes(5, 1, 1); idle(2);
        strobes(1, 0, 0); idle(2);
        chk("R9 no rearm with LD low", holdover_o, 0);
        chk("R10 comparator low blocks", holdover_o, 0);
        ld = 1'b1;
        strobes(5, 1, 1); idle(1);
        strobes(1, 0, 0); idle(1);
        chk("R10 comparator high rearms", holdover_o, 1);
        rsel = 1'b1;
        pulse_ref(2'b01);
        chk("R8 old reference ignored", holdover_o, 1);
        pulse_ref(2'b10);
        chk("R8 new selected reference exits", holdover_o, 0);
        rsel = 1'b0;

        code = 2'd1;
        strobes(15, 1, 1); chk("R2 code01 15", lock_o, 0);
        strobes(1, 1, 1);  chk("R2 code01 16", lock_o, 1);
        strobes(1, 0, 0);  idle(2); pulse_ref(2'b01);
        code = 2'd2;
        strobes(63, 1, 1); chk("R2 code10 63", lock_o, 0);
        strobes(1, 1, 1);  chk("R2 code10 64", lock_o, 1);
        strobes(1, 0, 0);  idle(2); pulse_ref(2'b01);
        code = 2'd3;
        strobes(254, 1, 1); chk("R2 code11 254", lock_o, 0);
        strobes(1, 1, 1);   chk("R2 code11 255", lock_o, 1);
        strobes(10, 1, 1);  chk("R2 saturation keeps lock", lock_o, 1);
        idle(20);           chk("R3 idle keeps lock", lock_o, 1);

        narrow = 1'b1;
        strobes(1, 1, 0);
        chk("R4 narrow flag bad clears", lock_o, 0);
        idle(2); pulse_ref(2'b01);
        code = 2'd0;
        strobes(5, 0, 1);
        chk("R4 narrow flag counts, wide ignored", lock_o, 1);
        narrow = 1'b0;
        idle(1);

        dld_off = 1'b1;
        idle(1);
        chk("R5 disable drops lock", lock_o, 0);
        idle(3);
        chk("R5 no automatic holdover", holdover_o, 0);
        strobes(6, 1, 1);
        chk("R5 no lock while disabled", lock_o, 0);
        dld_off = 1'b0;

        hen = 1'b0;
        strobes(5, 1, 1); idle(2); strobes(1, 0, 0); idle(2);
        chk("R6 auto gated", holdover_o, 0);
        ext = 1'b1; ereq = 1'b1;
        idle(1);
        chk("R6 external gated", holdover_o, 0);
        hen = 1'b1;
        #1 chk("R11 external follows same cycle", holdover_o, 1);
        idle(1);
        ereq = 1'b0;
        #1 chk("R11 external release", holdover_o, 0);
        strobes(5, 1, 1); idle(2); strobes(1, 0, 0); idle(2);
        chk("R11 no auto in external mode", holdover_o, 0);
        ext = 1'b0;

        for (int c = 0; c < 4000; c++) begin
            if (c % 250 == 0) begin
                code = ($urandom % 4 == 0) ? 2'd1 : 2'd0;
                narrow = $urandom % 2;
                dld_off = ($urandom % 8 == 0);
                hen = ($urandom % 6 != 0);
                ext = ($urandom % 5 == 0);
                ld_en = $urandom % 2;
                rsel = $urandom % 2;
            end
            strobe = $urandom % 2;
            wok = ($urandom % 100) < 93;
            nok = ($urandom % 100) < 90;
            redge = {($urandom % 25 == 0), ($urandom % 25 == 0)};
            if ($urandom % 20 == 0) ld = ~ld;
            if ($urandom % 15 == 0) ereq = ~ereq;
            rst = ($urandom % 1000 == 0);
            tick();
        end
        rst = 1'b0;
        strobe = 1'b0; redge = 2'b00;
        idle(2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule